// File: doc/BRIEF.md
# Conditional Fixed-Point Multiply Stage

This block is the multiply step of a 16-bit fixed-point DSP datapath. Each request carries an X and a Y operand, a format code, a square flag, a rounding-style flag, a destination select and a condition result from elsewhere in the pipeline. When the condition is true and the format is legal, the block forms the product and registers it on the next clock edge. The product goes either to a 40-bit result held as three words or to a 16-bit feedback word. When the condition is false, nothing changes.

The format code sets, for each operand on its own, whether it is read as two's complement or as unsigned. A fifth code asks for a signed product rounded to the upper half. Square mode feeds the X operand to both multiplier inputs. An illegal code produces an error strobe and the block writes nothing.

Top module: `cmul_stage`

## Requirements
- R1: When `req` is high and `cond_ok` is low, the next clock edge leaves `res_hi`, `res_mid`, `res_low` and `fb_q` unchanged and `res_vld` low.
- R2: `fmt` codes 0, 1, 2 and 3 read X/Y as signed/signed, signed/unsigned, unsigned/signed and unsigned/unsigned respectively. The first letter of each pair applies to X.
- R3: The full product is written as 40 bits: `res_hi` = bits 39..32, `res_mid` = bits 31..16, `res_low` = bits 15..0. If either operand is signed, the upper bits are a sign extension; with code 3 they are zero.
- R4: With `square` high, the Y input is ignored and X is multiplied by itself.
- R5: Code 4 (round) treats both operands as signed, adds one half at bit 15, and clears bits 15..0 of the stored value. A carry from the addition propagates into the upper bits.
- R6: In round mode with `biased_rnd` low, a product whose bits 15..0 equal exactly 0x8000 rounds so that bit 16 ends up 0 (half to even). With `biased_rnd` high, that case always rounds up.
- R7: With `dst_fb` high, `fb_q` receives bits 31..16 of the (possibly rounded) product and the three result words keep their values. With `dst_fb` low, the result words are written and `fb_q` keeps its value.
- R8: Codes 5 to 7, and codes 1 or 2 together with `square`, are illegal. One cycle later `fmt_err` pulses high, `res_vld` stays low and no output word changes. This holds whatever the value of `cond_ok`.
- R9: An executed request raises `res_vld` for exactly one cycle, on the edge after the request. With `req` low, no output word changes and both strobes are low.
- R10: Synchronous reset clears all output words and both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid |
| cond_ok | input | 1 | Condition result; 1 executes the request |
| square | input | 1 | Use X for both multiplier inputs |
| fmt | input | 3 | Format code (0 SS, 1 SU, 2 US, 3 UU, 4 round) |
| biased_rnd | input | 1 | 1 = biased rounding, 0 = half to even |
| dst_fb | input | 1 | 1 = write feedback word, 0 = write result words |
| x_op | input | 16 | X operand |
| y_op | input | 16 | Y operand |
| res_hi | output | 8 | Result bits 39..32 |
| res_mid | output | 16 | Result bits 31..16 |
| res_low | output | 16 | Result bits 15..0 |
| fb_q | output | 16 | Feedback word |
| res_vld | output | 1 | One-cycle strobe for an executed request |
| fmt_err | output | 1 | One-cycle strobe for an illegal format |

## Verification
The hardest case to reach is the exact rounding tie, because only particular operand pairs leave bits 15..0 of the product at exactly 0x8000. The stimulus table uses such pairs with bit 16 both even and odd, and with both positive and negative products. Each pair is run under both rounding styles, so the two styles disagree exactly where they should. A product of -1 in round mode checks that the carry wraps the full 40 bits back to zero.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  typedef enum logic [2:0] {
    FMT_SS  = 3'd0,
    FMT_SU  = 3'd1,
    FMT_US  = 3'd2,
    FMT_UU  = 3'd3,
    FMT_RND = 3'd4
  } fmt_e;

  // legal code, and no mixed-sign code while squaring
  function automatic logic fmt_legal(input logic [2:0] f, input logic sq);
    fmt_legal = (f <= FMT_RND) && !(sq && (f == FMT_SU || f == FMT_US));
  endfunction

  function automatic logic x_is_signed(input logic [2:0] f);
    x_is_signed = (f == FMT_SS) || (f == FMT_SU) || (f == FMT_RND);
  endfunction

  function automatic logic y_is_signed(input logic [2:0] f);
    y_is_signed = (f == FMT_SS) || (f == FMT_US) || (f == FMT_RND);
  endfunction
endpackage

// File: rtl/cmul_opext.sv
module cmul_opext #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   op,
  input  logic            is_signed,
  output logic signed [DW:0] ext
);
  // one extra bit makes unsigned values positive in a signed multiply
  assign ext = {is_signed & op[DW-1], op};
endmodule

// File: rtl/cmul_rnd.sv
module cmul_rnd #(
  parameter int W  = 40,
  parameter int RP = 16
) (
  input  logic [W-1:0] p,
  input  logic         biased,
  output logic [W-1:0] r
);
  localparam logic [W-1:0] HALF = {{(W-1){1'b0}}, 1'b1} << (RP-1);

  logic [W-1:0] sum;
  logic         tie;

  assign sum = p + HALF;
  assign tie = (p[RP-1:0] == HALF[RP-1:0]);

  always_comb begin
    r = sum;
    if (tie && !biased) r[RP] = 1'b0;
    r[RP-1:0] = '0;
  end
endmodule

// File: rtl/cmul_stage.sv
module cmul_stage #(
  parameter int DW    = 16,
  parameter int ACC_W = 40
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic                  cond_ok,
  input  logic                  square,
  input  logic [2:0]            fmt,
  input  logic                  biased_rnd,
  input  logic                  dst_fb,
  input  logic [DW-1:0]         x_op,
  input  logic [DW-1:0]         y_op,
  output logic [ACC_W-2*DW-1:0] res_hi,
  output logic [DW-1:0]         res_mid,
  output logic [DW-1:0]         res_low,
  output logic [DW-1:0]         fb_q,
  output logic                  res_vld,
  output logic                  fmt_err
);
  import cmul_pkg::*;

  localparam int HI_W = ACC_W - 2*DW;
  localparam int PW   = 2*DW + 2;

  logic [DW-1:0]       y_src;
  logic signed [DW:0]  xe, ye;
  logic signed [PW-1:0] prod;
  logic [ACC_W-1:0]    full, rnd_v, res_v;
  logic                legal;

  assign y_src = square ? x_op : y_op;

  cmul_opext #(.DW(DW)) u_xext (.op(x_op),  .is_signed(x_is_signed(fmt)), .ext(xe));
  cmul_opext #(.DW(DW)) u_yext (.op(y_src), .is_signed(y_is_signed(fmt)), .ext(ye));

  assign prod = $signed({{(PW-DW-1){xe[DW]}}, xe}) * $signed({{(PW-DW-1){ye[DW]}}, ye});
  assign full = {{(ACC_W-PW){prod[PW-1]}}, prod};

  cmul_rnd #(.W(ACC_W), .RP(DW)) u_rnd (.p(full), .biased(biased_rnd), .r(rnd_v));

  assign res_v = (fmt == FMT_RND) ? rnd_v : full;
  assign legal = fmt_legal(fmt, square);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_hi  <= '0;
      res_mid <= '0;
      res_low <= '0;
      fb_q    <= '0;
      res_vld <= 1'b0;
      fmt_err <= 1'b0;
    end else begin
      res_vld <= 1'b0;
      fmt_err <= req && !legal;
      if (req && legal && cond_ok) begin
        res_vld <= 1'b1;
        if (dst_fb) begin
          fb_q <= res_v[2*DW-1:DW];
        end else begin
          res_hi  <= res_v[ACC_W-1:2*DW];
          res_mid <= res_v[2*DW-1:DW];
          res_low <= res_v[DW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/cmul_chk.sv
module cmul_chk #(
  parameter int DW   = 16,
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            req,
  input logic            cond_ok,
  input logic            square,
  input logic [2:0]      fmt,
  input logic            dst_fb,
  input logic [HI_W-1:0] res_hi,
  input logic [DW-1:0]   res_mid,
  input logic [DW-1:0]   res_low,
  input logic [DW-1:0]   fb_q,
  input logic            res_vld,
  input logic            fmt_err
);
  logic mixed_sq, ok_code;
  assign mixed_sq = square && (fmt == 3'd1 || fmt == 3'd2);
  assign ok_code  = (fmt <= 3'd4) && !mixed_sq;

  AST_NOOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req && !cond_ok && ok_code) |=> (!res_vld && $stable(res_hi) && $stable(res_mid) && $stable(res_low) && $stable(fb_q))); // R1
  AST_UU_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req && cond_ok && !dst_fb && fmt == 3'd3) |=> (res_hi == '0)); // R3
  AST_RND_LOW_CLR: assert property (@(posedge clk) disable iff (rst)
    (req && cond_ok && !dst_fb && fmt == 3'd4) |=> (res_low == '0)); // R5
  AST_FB_KEEPS_RES: assert property (@(posedge clk) disable iff (rst)
    (req && cond_ok && dst_fb && ok_code) |=> ($stable(res_hi) && $stable(res_mid) && $stable(res_low))); // R7
  AST_SQ_MIXED_ERR: assert property (@(posedge clk) disable iff (rst)
    (req && mixed_sq) |=> (fmt_err && !res_vld && $stable(fb_q) && $stable(res_mid))); // R8
  AST_BAD_CODE_ERR: assert property (@(posedge clk) disable iff (rst)
    (req && fmt > 3'd4) |=> (fmt_err && !res_vld)); // R8
  AST_VLD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $past(req && cond_ok)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!res_vld && !fmt_err && $stable(fb_q) && $stable(res_low))); // R9
endmodule

bind cmul_stage cmul_chk #(.DW(DW), .HI_W(ACC_W - 2*DW)) u_chk (
  .clk(clk), .rst(rst), .req(req), .cond_ok(cond_ok), .square(square),
  .fmt(fmt), .dst_fb(dst_fb), .res_hi(res_hi), .res_mid(res_mid),
  .res_low(res_low), .fb_q(fb_q), .res_vld(res_vld), .fmt_err(fmt_err)
);

// File: tb/sim_cmul_stage.sv
module sim_cmul_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, cond_ok = 1'b0, square = 1'b0, biased_rnd = 1'b0, dst_fb = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic [15:0] x_op = '0, y_op = '0;
  logic [7:0]  res_hi;
  logic [15:0] res_mid, res_low, fb_q;
  logic        res_vld, fmt_err;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cmul_stage u0 (
    .clk(clk), .rst(rst), .req(req), .cond_ok(cond_ok), .square(square),
    .fmt(fmt), .biased_rnd(biased_rnd), .dst_fb(dst_fb), .x_op(x_op), .y_op(y_op),
    .res_hi(res_hi), .res_mid(res_mid), .res_low(res_low), .fb_q(fb_q),
    .res_vld(res_vld), .fmt_err(fmt_err)
  );

  // {square, fmt, biased, x, y, expected 40-bit result}
  localparam int NV = 14;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 3'd0, 1'b0, 16'h0003, 16'hFFFE, 40'hFF_FFFF_FFFA}, // R2 SS
    {1'b0, 3'd3, 1'b0, 16'hFFFF, 16'hFFFF, 40'h00_FFFE_0001}, // R3 UU
    {1'b0, 3'd1, 1'b0, 16'hFFFF, 16'hFFFF, 40'hFF_FFFF_0001}, // R2 SU
    {1'b0, 3'd2, 1'b0, 16'hFFFF, 16'h0002, 40'h00_0001_FFFE}, // R2 US
    {1'b1, 3'd0, 1'b0, 16'h8000, 16'h0005, 40'h00_4000_0000}, // R4 SS square
    {1'b1, 3'd3, 1'b0, 16'h0100, 16'h1234, 40'h00_0001_0000}, // R4 UU square
    {1'b0, 3'd4, 1'b0, 16'h0001, 16'h8000, 40'h00_0000_0000}, // R6 -half to even
    {1'b0, 3'd4, 1'b0, 16'h0002, 16'h4000, 40'h00_0000_0000}, // R6 +half to even
    {1'b0, 3'd4, 1'b1, 16'h0002, 16'h4000, 40'h00_0001_0000}, // R6 biased up
    {1'b0, 3'd4, 1'b0, 16'h0003, 16'h8000, 40'hFF_FFFE_0000}, // R6 odd half even
    {1'b0, 3'd4, 1'b1, 16'h0003, 16'h8000, 40'hFF_FFFF_0000}, // R6 odd half biased
    {1'b0, 3'd4, 1'b0, 16'h00FF, 16'h00FF, 40'h00_0001_0000}, // R5 carry up
    {1'b0, 3'd4, 1'b0, 16'hFFFF, 16'h0001, 40'h00_0000_0000}, // R5 -1 wraps to 0
    {1'b1, 3'd4, 1'b0, 16'h0100, 16'h7777, 40'h00_0001_0000}  // R4 R5 square round
  };
  localparam int TAG [NV] = '{2, 3, 2, 2, 4, 4, 6, 6, 6, 6, 6, 5, 5, 4};

  task automatic check(input string rq, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic op(input logic sq, input logic [2:0] f, input logic b, input logic [15:0] x,
                    input logic [15:0] y, input logic fb, input logic c);
    @(negedge clk);
    square = sq; fmt = f; biased_rnd = b; x_op = x; y_op = y; dst_fb = fb; cond_ok = c; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 words", {res_hi, res_mid, res_low}, 40'h0);
    check("R10 strobes", {38'h0, res_vld, fmt_err}, 40'h0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][76], VEC[i][75:73], VEC[i][72], VEC[i][71:56], VEC[i][55:40], 1'b0, 1'b1);
      check($sformatf("R%0d vector %0d", TAG[i], i), {res_hi, res_mid, res_low}, VEC[i][39:0]);
      check("R9 vld high", {39'h0, res_vld}, 40'h1);
    end
    @(negedge clk);
    check("R9 vld one cycle", {39'h0, res_vld}, 40'h0);

    // R7 feedback destination
    op(1'b0, 3'd0, 1'b0, 16'h0003, 16'hFFFE, 1'b1, 1'b1);
    check("R7 fb word", {24'h0, fb_q}, 40'h0000_FFFF);
    check("R7 result kept", {res_hi, res_mid, res_low}, 40'h00_0001_0000);
    op(1'b0, 3'd4, 1'b0, 16'h00FF, 16'h00FF, 1'b1, 1'b1);
    check("R7 fb rounded", {24'h0, fb_q}, 40'h0000_0001);
    op(1'b0, 3'd0, 1'b0, 16'h0002, 16'h0003, 1'b0, 1'b1);
    check("R7 fb kept", {24'h0, fb_q}, 40'h0000_0001);
    check("R7 result written", {res_hi, res_mid, res_low}, 40'h00_0000_0006);

    // R1 condition false
    op(1'b0, 3'd0, 1'b0, 16'h1234, 16'h0100, 1'b0, 1'b0);
    check("R1 result kept", {res_hi, res_mid, res_low}, 40'h00_0000_0006);
    check("R1 no vld", {39'h0, res_vld}, 40'h0);
    op(1'b0, 3'd3, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
    check("R1 fb kept", {24'h0, fb_q}, 40'h0000_0001);

    // R8 illegal formats
    op(1'b1, 3'd1, 1'b0, 16'h0005, 16'h0005, 1'b0, 1'b1);
    check("R8 sq SU err", {38'h0, res_vld, fmt_err}, 40'h1);
    check("R8 sq SU no write", {res_hi, res_mid, res_low}, 40'h00_0000_0006);
    op(1'b0, 3'd6, 1'b0, 16'h0005, 16'h0005, 1'b1, 1'b0);
    check("R8 code6 err", {38'h0, res_vld, fmt_err}, 40'h1);
    check("R8 code6 fb kept", {24'h0, fb_q}, 40'h0000_0001);
    @(negedge clk);
    check("R9 idle strobes", {38'h0, res_vld, fmt_err}, 40'h0);

    // R10 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 words after run", {res_hi, res_mid, res_low}, 40'h0);
    check("R10 fb after run", {24'h0, fb_q}, 40'h0);

    finish_run();
  end
endmodule